// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block collects level-sensitive system interrupt sources (device lines, expansion-bus and VME request levels, error lines) for a small shared-memory multiprocessor of up to four CPUs. It also computes a 4-bit processor interrupt level for each CPU. Every clock it samples the sources into a system pending word. A global mask word decides which sources take part. The mask can only be changed through two write-only words: one that disables sources and one that enables them. In both words a 1 bit acts and a 0 bit is ignored.

Unmasked system sources go only to the CPU named by a target register. Each CPU also owns fifteen software interrupt bits, which other CPUs raise and drop to send interprocessor interrupts. Each CPU has a per-CPU timer line at level 14. Each CPU's output is the highest level among everything that applies to it.

Software reaches the block over a plain 32-bit word-addressed register bus. The bus has a write strobe, a read strobe and a registered read return.

Top module: `mp_irq_mask_ctrl`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF, the target reads 0, every software pending word reads 0 and every CPU level output is 0.
- R2: A write to the mask-disable word (word address 3) sets each mask bit whose data bit is 1. Other mask bits keep their value. Reads of this word return 0.
- R3: A write to the mask-enable word (word address 2) clears each mask bit whose data bit is 1. Other mask bits keep their value. Reads of this word return 0. The mask word itself reads at word address 1.
- R4: The system pending word (word address 0) holds the sources sampled at every clock edge. Bits 31 and 23 to 26 always read 0, and writes to this word are ignored.
- R5: Each source bit drives one processor level:
  - VME lines at bits 0 to 6 and expansion-bus lines at bits 7 to 13 map their request levels 1 to 7 onto levels 2, 3, 5, 7, 9, 11 and 13.
  - Keyboard/mouse (bit 14) and serial (bit 15) map to level 12.
  - Audio (bit 16) maps to 13, ethernet (bit 17) to 6, the realtime timer (bit 18) to 10 and SCSI (bit 19) to 4.
  - Video (bit 20) maps to 8, the module interrupt (bit 21) to 9 and floppy (bit 22) to 11.
  - The four error bits 27 to 30 map to 15. Bits 23 to 26 drive nothing.
- R6: While mask bit 31 is 1, no system source reaches any CPU, whatever the other mask bits are.
- R7: Unmasked system sources reach only the CPU whose index is held in the target word (word address 4, readable and writable). A write of a value of NCPU or more leaves the target unchanged.
- R8: CPU c's words sit at word address 8+4c: pending at offset 0, drop at offset 1 and raise at offset 2. Raise and drop act on the 1 bits in positions 17 to 31 only. Bit 16+n is the software interrupt at level n. Data bits 0 to 16 and 0 bits have no effect.
- R9: A high per-CPU timer input gives that CPU level 14, independent of the mask and the target.
- R10: Each CPU's level output is a register. It is the highest level among that CPU's software bits, its timer and, for the target CPU only, the unmasked sources, or 0 when none applies. It is updated at the first clock edge that sees a source change, and at the edge after a register write takes effect.
- R11: Read data appears on the bus one clock after the read strobe. Unmapped addresses, including the words of CPUs that are not present, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRd |
| srcIn | input | 32 | Level-sensitive system interrupt sources |
| cpuTimer | input | NCPU | Per-CPU timer interrupt lines |
| irqLevel | output | 4*NCPU | Processor level per CPU, CPU c in bits 4c+3..4c |

## Verification
The assertions assume that the bus strobes, address and write data carry known values at every clock edge. They also assume at most one register write per cycle, so that the effect of a mask or software-bit write can be credited to that single transaction. The bench keeps to this by driving one transaction at a time from tasks. It changes strobes, data and source lines only at falling clock edges, and it returns every strobe to 0 before the next transaction starts.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int WORD_W     = 32;
  localparam int LVL_W      = 4;
  localparam int CPU_SEL_W  = 4;
  localparam int STRIDE_SH  = 2;
  localparam int CPU_BASE   = 8;
  localparam int SOFT_BASE  = 16;
  localparam int MASK_ALL   = 31;

  localparam int A_SYS_PEND = 0;
  localparam int A_MASK     = 1;
  localparam int A_MASK_EN  = 2;
  localparam int A_MASK_DIS = 3;
  localparam int A_TARGET   = 4;

  localparam int W_PEND  = 0;
  localparam int W_DROP  = 1;
  localparam int W_RAISE = 2;

  localparam logic [WORD_W-1:0] SRC_VALID  = 32'h787F_FFFF;
  localparam logic [WORD_W-1:0] SOFT_FIELD = 32'hFFFE_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SYSPEND,
    RD_MASK,
    RD_TARGET,
    RD_SOFT
  } rd_sel_e;

  typedef struct packed {
    logic                 maskDis;
    logic                 maskEn;
    logic                 tgtWr;
    logic                 softRaise;
    logic                 softDrop;
    logic                 rdEn;
    rd_sel_e              rdSel;
    logic [CPU_SEL_W-1:0] cpuSel;
  } imc_strobe_t;

  function automatic logic [LVL_W-1:0] srcLevel(input int unsigned bitIdx);
    logic [LVL_W-1:0] lvl;
    if (bitIdx <= 13) begin
      case (bitIdx % 7)
        0: lvl = 4'd2;
        1: lvl = 4'd3;
        2: lvl = 4'd5;
        3: lvl = 4'd7;
        4: lvl = 4'd9;
        5: lvl = 4'd11;
        default: lvl = 4'd13;
      endcase
    end else begin
      case (bitIdx)
        14, 15: lvl = 4'd12;
        16: lvl = 4'd13;
        17: lvl = 4'd6;
        18: lvl = 4'd10;
        19: lvl = 4'd4;
        20: lvl = 4'd8;
        21: lvl = 4'd9;
        22: lvl = 4'd11;
        27, 28, 29, 30: lvl = 4'd15;
        default: lvl = 4'd0;
      endcase
    end
    return lvl;
  endfunction
endpackage

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 5
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output imc_strobe_t       strb
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CPU_BASE);

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] cpuIdx;
  logic [1:0]        wordSel;

  assign offs    = busAddr - BASE_A;
  assign cpuIdx  = offs >> STRIDE_SH;
  assign wordSel = offs[1:0];

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    strb.rdEn   = busRd;
    if (busAddr < BASE_A) begin
      case (int'(busAddr))
        A_SYS_PEND: strb.rdSel = RD_SYSPEND;
        A_MASK:     strb.rdSel = RD_MASK;
        A_MASK_EN:  strb.maskEn = busWr;
        A_MASK_DIS: strb.maskDis = busWr;
        A_TARGET: begin
          strb.rdSel = RD_TARGET;
          strb.tgtWr = busWr;
        end
        default: strb.rdSel = RD_ZERO;
      endcase
    end else if (int'(cpuIdx) < NCPU) begin
      strb.cpuSel = CPU_SEL_W'(cpuIdx);
      case (int'(wordSel))
        W_PEND:  strb.rdSel = RD_SOFT;
        W_DROP:  strb.softDrop = busWr;
        W_RAISE: strb.softRaise = busWr;
        default: strb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/imc_regs.sv
module imc_regs
  import imc_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  imc_strobe_t                  strb,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [WORD_W-1:0]            srcIn,
  output logic [WORD_W-1:0]            maskQ,
  output logic [TGT_W-1:0]             tgtQ,
  output logic [NCPU-1:0][WORD_W-1:0]  softQ,
  output logic [WORD_W-1:0]            sysPendQ,
  output logic [WORD_W-1:0]            rdData
);
  logic [WORD_W-1:0] softSel;
  logic [WORD_W-1:0] rdNext;
  logic [WORD_W-1:0] softBits;

  assign softBits = wrData & SOFT_FIELD;

  always_comb begin
    softSel = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (strb.cpuSel == CPU_SEL_W'(c)) softSel = softQ[c];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_SYSPEND: rdNext = sysPendQ;
      RD_MASK:    rdNext = maskQ;
      RD_TARGET:  rdNext = WORD_W'(tgtQ);
      RD_SOFT:    rdNext = softSel;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= '1;
      tgtQ     <= '0;
      softQ    <= '0;
      sysPendQ <= '0;
      rdData   <= '0;
    end else begin
      sysPendQ <= srcIn & SRC_VALID;
      if (strb.maskDis)     maskQ <= maskQ | wrData;
      else if (strb.maskEn) maskQ <= maskQ & ~wrData;
      if (strb.tgtWr && (wrData < WORD_W'(NCPU))) tgtQ <= wrData[TGT_W-1:0];
      for (int c = 0; c < NCPU; c++) begin
        if (strb.cpuSel == CPU_SEL_W'(c)) begin
          if (strb.softRaise)     softQ[c] <= softQ[c] | softBits;
          else if (strb.softDrop) softQ[c] <= softQ[c] & ~softBits;
        end
      end
      rdData <= strb.rdEn ? rdNext : '0;
    end
  end
endmodule

// File: rtl/imc_prio.sv
module imc_prio
  import imc_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WORD_W-1:0]           srcIn,
  input  logic [WORD_W-1:0]           maskQ,
  input  logic [TGT_W-1:0]            tgtQ,
  input  logic [NCPU-1:0][WORD_W-1:0] softQ,
  input  logic [NCPU-1:0]             cpuTimer,
  output logic [NCPU*LVL_W-1:0]       levelQ
);
  localparam logic [LVL_W-1:0] TIMER_LVL = 4'd14;

  logic [LVL_W-1:0] sysLvl;

  always_comb begin
    sysLvl = '0;
    for (int b = 0; b < MASK_ALL; b++) begin
      if (srcIn[b] && !maskQ[b] && !maskQ[MASK_ALL] && (srcLevel(b) > sysLvl))
        sysLvl = srcLevel(b);
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [LVL_W-1:0] bestLvl;

    always_comb begin
      bestLvl = '0;
      for (int n = 1; n < 16; n++) begin
        if (softQ[c][SOFT_BASE+n]) bestLvl = LVL_W'(n);
      end
      if (cpuTimer[c] && (TIMER_LVL > bestLvl)) bestLvl = TIMER_LVL;
      if ((tgtQ == TGT_W'(c)) && (sysLvl > bestLvl)) bestLvl = sysLvl;
    end

    always_ff @(posedge clk) begin
      if (!rstN) levelQ[c*LVL_W +: LVL_W] <= '0;
      else       levelQ[c*LVL_W +: LVL_W] <= bestLvl;
    end
  end
endmodule

// File: rtl/mp_irq_mask_ctrl.sv
module mp_irq_mask_ctrl
  import imc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  input  logic [31:0]             srcIn,
  input  logic [NCPU-1:0]         cpuTimer,
  output logic [NCPU*4-1:0]       irqLevel
);
  localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  imc_strobe_t                  strb;
  logic [WORD_W-1:0]            maskQ;
  logic [TGT_W-1:0]             tgtQ;
  logic [NCPU-1:0][WORD_W-1:0]  softQ;
  logic [WORD_W-1:0]            sysPendQ;

  imc_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .strb   (strb)
  );

  imc_regs #(.NCPU(NCPU), .TGT_W(TGT_W)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .srcIn   (srcIn),
    .maskQ   (maskQ),
    .tgtQ    (tgtQ),
    .softQ   (softQ),
    .sysPendQ(sysPendQ),
    .rdData  (busRdData)
  );

  imc_prio #(.NCPU(NCPU), .TGT_W(TGT_W)) u_prio (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .maskQ   (maskQ),
    .tgtQ    (tgtQ),
    .softQ   (softQ),
    .cpuTimer(cpuTimer),
    .levelQ  (irqLevel)
  );
endmodule

// File: rtl/imc_checker.sv
module imc_checker
  import imc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input imc_strobe_t                 strb,
  input logic [31:0]                 wrData,
  input logic [31:0]                 maskQ,
  input logic [NCPU-1:0][31:0]       softQ,
  input logic [NCPU-1:0]             cpuTimer,
  input logic [NCPU*4-1:0]           irqLevel
);
  // R2: disabled bits end up set
  p_mask_dis_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskDis |=> ((maskQ & $past(wrData)) == $past(wrData)));

  // R3: enabled bits end up clear
  p_mask_en_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskEn |=> ((maskQ & $past(wrData)) == 32'd0));

  // R2 and R3: without a mask write the mask holds
  p_mask_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.maskDis && !strb.maskEn) |=> $stable(maskQ));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    // R8: raise sets the addressed software bits
    p_soft_raise_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.softRaise && strb.cpuSel == CPU_SEL_W'(c)) |=>
        ((softQ[c] & $past(wrData) & SOFT_FIELD) == ($past(wrData) & SOFT_FIELD)));

    // R8: drop clears the addressed software bits
    p_soft_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.softDrop && strb.cpuSel == CPU_SEL_W'(c)) |=>
        ((softQ[c] & $past(wrData) & SOFT_FIELD) == 32'd0));

    // R6 and R10: all system sources masked, no soft bit, no timer -> level 0
    p_quiet_level_r6: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[31] && (softQ[c] & SOFT_FIELD) == 32'd0 && !cpuTimer[c]) |=>
        (irqLevel[c*4 +: 4] == 4'd0));

    // R9: timer gives at least level 14
    p_timer_floor_r9: assert property (@(posedge clk) disable iff (!rstN)
      cpuTimer[c] |=> (irqLevel[c*4 +: 4] >= 4'd14));
  end
endmodule

bind mp_irq_mask_ctrl imc_checker #(.NCPU(NCPU)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .wrData  (busWrData),
  .maskQ   (maskQ),
  .softQ   (softQ),
  .cpuTimer(cpuTimer),
  .irqLevel(irqLevel)
);

// File: tb/mp_irq_mask_ctrl_bench.sv
module mp_irq_mask_ctrl_bench;
  localparam int NCPU   = 4;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [31:0]       srcIn = '0;
  logic [NCPU-1:0]   cpuTimer = '0;
  logic [NCPU*4-1:0] irqLevel;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mp_irq_mask_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_mp_irq_mask_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .srcIn(srcIn),
    .cpuTimer(cpuTimer), .irqLevel(irqLevel)
  );

  function automatic logic [3:0] expLvl(input int b);
    case (b)
      0, 7: return 4'd2;
      1, 8: return 4'd3;
      2, 9: return 4'd5;
      3, 10: return 4'd7;
      4, 11: return 4'd9;
      5, 12: return 4'd11;
      6, 13: return 4'd13;
      14, 15: return 4'd12;
      16: return 4'd13;
      17: return 4'd6;
      18: return 4'd10;
      19: return 4'd4;
      20: return 4'd8;
      21: return 4'd9;
      22: return 4'd11;
      27, 28, 29, 30: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] lvl(input int c);
    return irqLevel[c*4 +: 4];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = ADDR_W'(addr); busWrData = data;
    @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    busRd = 1'b1; busAddr = ADDR_W'(addr);
    @(negedge clk);
    busRd = 1'b0;
    data = busRdData;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < NCPU; c++) chk("R1 level", 32'(lvl(c)), 32'd0);
    rd(1, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(4, v); chk("R1 target", v, 32'd0);
    rd(8, v); chk("R1 soft cpu0", v, 32'd0);
    rd(20, v); chk("R1 soft cpu3", v, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(2, 32'h0000_00FF); rd(1, v); chk("R3 enable", v, 32'hFFFF_FF00);
    wr(2, 32'h0); rd(1, v); chk("R3 zero no effect", v, 32'hFFFF_FF00);
    wr(3, 32'h0000_000F); rd(1, v); chk("R2 disable", v, 32'hFFFF_FF0F);
    wr(3, 32'h0); rd(1, v); chk("R2 zero no effect", v, 32'hFFFF_FF0F);
    rd(2, v); chk("R3 write-only read", v, 32'd0);
    rd(3, v); chk("R2 write-only read", v, 32'd0);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    @(negedge clk); srcIn = 32'hFF80_1234;
    rd(0, v); chk("R4 sampled", v, 32'h7800_1234);
    wr(0, 32'h0);
    rd(0, v); chk("R4 write ignored", v, 32'h7800_1234);
    @(negedge clk); srcIn = 32'h0000_0001;
    rd(0, v); chk("R4 follows source", v, 32'h0000_0001);
    @(negedge clk); srcIn = '0;
    settle();
  endtask

  task automatic t_levelmap();
    wr(2, 32'hFFFF_FFFF);
    for (int b = 0; b < 31; b++) begin
      srcIn = 32'h1 << b;
      settle();
      chk($sformatf("R5 bit %0d cpu0", b), 32'(lvl(0)), 32'(expLvl(b)));
      chk("R7 non-target cpu1", 32'(lvl(1)), 32'd0);
    end
    srcIn = (32'h1 << 19) | (32'h1 << 18) | (32'h1 << 17);
    settle();
    chk("R10 highest wins", 32'(lvl(0)), 32'd10);
    srcIn = '0;
    settle();
    chk("R10 idle zero", 32'(lvl(0)), 32'd0);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_maskall();
    wr(2, 32'hFFFF_FFFF);
    srcIn = 32'h1 << 27;
    settle();
    chk("R10 error level", 32'(lvl(0)), 32'd15);
    wr(3, 32'h8000_0000); settle();
    chk("R6 mask-all", 32'(lvl(0)), 32'd0);
    wr(2, 32'h8000_0000); wr(3, 32'h1 << 27); settle();
    chk("R2 single bit masked", 32'(lvl(0)), 32'd0);
    srcIn = (32'h1 << 27) | (32'h1 << 19);
    settle();
    chk("R2 other bit passes", 32'(lvl(0)), 32'd4);
    srcIn = '0;
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_target();
    logic [31:0] v;
    wr(2, 32'hFFFF_FFFF);
    srcIn = 32'h1 << 18;
    wr(4, 2); settle();
    chk("R7 cpu2 gets system", 32'(lvl(2)), 32'd10);
    chk("R7 cpu0 none", 32'(lvl(0)), 32'd0);
    rd(4, v); chk("R7 target read", v, 32'd2);
    wr(4, 7); rd(4, v); chk("R7 out-of-range ignored", v, 32'd2);
    wr(4, 0);
    srcIn = '0;
    wr(3, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(14, (32'h1 << 19) | (32'h1 << 25)); settle();
    chk("R8 cpu1 soft level", 32'(lvl(1)), 32'd9);
    chk("R8 cpu0 untouched", 32'(lvl(0)), 32'd0);
    rd(12, v); chk("R8 cpu1 pending", v, 32'h0208_0000);
    wr(14, 32'h0001_FFFF); rd(12, v); chk("R8 low bits ignored", v, 32'h0208_0000);
    wr(13, 32'h1 << 25); settle();
    chk("R8 drop", 32'(lvl(1)), 32'd3);
    wr(13, 32'h0); rd(12, v); chk("R8 zero drop no effect", v, 32'h0008_0000);
    wr(13, 32'hFFFF_FFFF); settle();
    chk("R8 all dropped", 32'(lvl(1)), 32'd0);
  endtask

  task automatic t_prio();
    wr(2, 32'hFFFF_FFFF);
    wr(4, 3);
    srcIn = 32'h1 << 18;
    cpuTimer = 4'b1000;
    settle();
    chk("R9 timer over system", 32'(lvl(3)), 32'd14);
    wr(22, 32'h8000_0000); settle();
    chk("R10 soft 15 on top", 32'(lvl(3)), 32'd15);
    wr(21, 32'h8000_0000);
    cpuTimer = 4'b0000;
    wr(3, 32'hFFFF_FFFF); settle();
    chk("R9 masked mask-all keeps timer off", 32'(lvl(3)), 32'd0);
    cpuTimer = 4'b1000; settle();
    chk("R9 timer ignores mask", 32'(lvl(3)), 32'd14);
    cpuTimer = '0; srcIn = '0;
    wr(4, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(5, v);  chk("R11 addr 5", v, 32'd0);
    rd(11, v); chk("R11 cpu0 spare word", v, 32'd0);
    rd(24, v); chk("R11 absent cpu", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_mask();
    t_pending();
    t_levelmap();
    t_maskall();
    t_target();
    t_soft();
    t_prio();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule